// File: doc/BRIEF.md
# Configuration Download Sequencer

This block is a bus master that operates a configuration port controller through its register bank. It replaces the host routine that used to do this work. It has two jobs, and each starts from a one-cycle command.

The first job is identification. The master silences the controller's interrupt output and checks that the controller is present and idle. It then pushes a fixed seven-word command stream that asks the device for its identity. After the controller reports completion, the master requests one word into the read FIFO, switches the controller to read mode and captures that word as the device ID.

The second job is download. The bitstream is pulled word by word from a valid/ready source. It is written in bursts, and each burst is no larger than the free FIFO space the controller reports. Every burst ends with a start command, followed by a bounded poll until the start bit clears. After the last burst, a bounded completion poll runs. The job ends with a one-cycle done pulse and a result code.

Top module: `cdl_seq_top`

## Requirements
- R1: After reset the bus request, source ready and done outputs are low, the result code is 0 and the captured ID is 0.
- R2: On a probe command the master writes 0 to the interrupt-enable register (byte address 0x01C) and then reads status (0x110); a status other than exactly 0x1 ends the job with result 1 (no device).
- R3: During probe the master then reads the vacancy register (0x114); a value below 8 ends the job with result 1.
- R4: The probe then writes 0xFFFFFFFF, 0xAA995566, 0x20000000, 0x20000000, 0x28018001, 0x20000000, 0x20000000 in that order to the write FIFO (0x100), followed by the value 1 to control (0x10C).
- R5: After each write of 1 to control, the master reads control up to 20 times, at least CR_GAP cycles apart; if bit 0 is set on the 20th read, the job ends with result 2 (I/O error).
- R6: A completion poll waits at least SR_GAP cycles before each status read, for up to 10 reads; it succeeds when bit 0 or bit 2 is set, and otherwise ends the job with result 3 (timeout).
- R7: After the first completion of the probe, the master writes 1 to the size register (0x108) and 2 to control, runs a second completion poll, reads the read FIFO (0x104), presents that word on the ID output and ends with result 0.
- R8: A download whose byte length is not a multiple of 4 ends at once with result 4 (bad length), with no bus access and no word taken from the source.
- R9: A download repeats the following until all words are sent: read vacancy, send min(vacancy, words left) source words in source order to the write FIFO, write 1 to control, then run the control poll.
- R10: A vacancy of 0 read during a download ends the job with result 2.
- R11: After the last burst of a download, a completion poll runs; on success the job ends with result 0.
- R12: Done is high for exactly one cycle per job, and probe or start commands that arrive while a job is running have no effect.
- R13: A bus request is held with address, direction and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_i | input | 1 | Start an identification job (has priority over start_i) |
| start_i | input | 1 | Start a download job |
| len_bytes_i | input | LEN_W | Download length in bytes, sampled with start_i |
| src_valid_i | input | 1 | Source word available |
| src_data_i | input | 32 | Source word |
| src_ready_o | output | 1 | Source word taken when both ready and valid are high |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 12 | Register byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Access complete; read data valid |
| bus_rdata_i | input | 32 | Read data |
| id_o | output | 32 | Captured device ID |
| done_o | output | 1 | One-cycle job-end pulse |
| err_o | output | 3 | Result: 0 ok, 1 no device, 2 I/O error, 3 timeout, 4 bad length |

## Verification
A wrong state in the sequencer shows up on the bus within one access. That access has the wrong address or data, is issued out of order, or is missing before done. The bench compares every accepted access against an expected transaction list as soon as it is acknowledged. A corrupted poll counter or gap timer shows up instead as a done pulse that comes too early or too late, or as an access count that differs from the list. The bench measures the timeout job's length and counts control and status reads to catch these.

// File: rtl/cdl_pkg.sv
// Shared constants and types for the configuration download sequencer.
// Assumes a 32-bit register bus with 12-bit byte addresses.
package cdl_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int ID_WORDS = 7;

    // register byte addresses the controller decodes
    localparam logic [ADDR_W-1:0] REG_IRQ_EN = 12'h01C;
    localparam logic [ADDR_W-1:0] REG_WFIFO  = 12'h100;
    localparam logic [ADDR_W-1:0] REG_RFIFO  = 12'h104;
    localparam logic [ADDR_W-1:0] REG_SIZE   = 12'h108;
    localparam logic [ADDR_W-1:0] REG_CTRL   = 12'h10C;
    localparam logic [ADDR_W-1:0] REG_STAT   = 12'h110;
    localparam logic [ADDR_W-1:0] REG_VACANT = 12'h114;

    typedef enum logic [2:0] {
        CDL_OK      = 3'd0,
        CDL_NODEV   = 3'd1,
        CDL_IOERR   = 3'd2,
        CDL_TIMEOUT = 3'd3,
        CDL_BADLEN  = 3'd4
    } cdl_err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_IRQ_OFF, S_STAT_CHK, S_VAC_CHK, S_ID_WR, S_KICK,
        S_CR_RD, S_CR_WAIT, S_CMP_WAIT, S_CMP_RD, S_SIZE_WR, S_RDMODE,
        S_RF_RD, S_DL_VAC, S_FETCH, S_DL_WR
    } cdl_state_e;
endpackage

// File: rtl/cdl_id_stream.sv
// Canned identification command stream, selected by word index.
// Assumes idx_i < 7; other indices return a no-op word.
module cdl_id_stream (
    input  logic [2:0]  idx_i,
    output logic [31:0] word_o
);
    // select the command word for the current index
    always_comb begin
        case (idx_i)
            3'd0:    word_o = 32'hFFFF_FFFF;
            3'd1:    word_o = 32'hAA99_5566;
            3'd4:    word_o = 32'h2801_8001;
            default: word_o = 32'h2000_0000;
        endcase
    end
endmodule

// File: rtl/cdl_gap_timer.sv
// Poll-gap down counter: reloads while load_i is high, counts down
// otherwise, and reports expiry at zero. Assumes value_i fits in W bits.
module cdl_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         expired_o
);
    logic [W-1:0] cnt;

    // reload or count toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load_i)      cnt <= value_i;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired_o = (cnt == '0);
endmodule

// File: rtl/cdl_burst_calc.sv
// Burst sizing: the smaller of the reported vacancy and the words left.
// Assumes CW <= 32.
module cdl_burst_calc #(
    parameter int CW = 22
) (
    input  logic [31:0]   vac_i,
    input  logic [CW-1:0] remain_i,
    output logic [CW-1:0] burst_o,
    output logic          vac_zero_o
);
    // clamp the burst to the free space
    always_comb begin
        if (vac_i < 32'(remain_i)) burst_o = vac_i[CW-1:0];
        else                       burst_o = remain_i;
        vac_zero_o = (vac_i == 32'd0);
    end
endmodule

// File: rtl/cdl_seq_top.sv
// Configuration download sequencer: runs the identification probe and
// the FIFO-paced bitstream download against the configuration port
// controller's registers. Assumes the responder acks each request once
// and presents read data in the ack cycle.
module cdl_seq_top
    import cdl_pkg::*;
#(
    parameter int CLK_MHZ   = 50,
    parameter int LEN_W     = 24,
    parameter int CR_POLLS  = 20,
    parameter int SR_POLLS  = 10,
    parameter int CR_GAP_NS = 50,
    parameter int SR_GAP_NS = 5000,
    parameter int MIN_VAC   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              probe_i,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_bytes_i,
    input  logic              src_valid_i,
    input  logic [31:0]       src_data_i,
    output logic              src_ready_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [31:0]       bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [31:0]       bus_rdata_i,
    output logic [31:0]       id_o,
    output logic              done_o,
    output logic [2:0]        err_o
);
    localparam int WORD_W = LEN_W - 2;
    localparam int CR_GAP = (CLK_MHZ * CR_GAP_NS + 999) / 1000;
    localparam int SR_GAP = (CLK_MHZ * SR_GAP_NS + 999) / 1000;
    localparam int MAXGAP = (CR_GAP > SR_GAP) ? CR_GAP : SR_GAP;
    localparam int GAP_W  = $clog2(MAXGAP + 1);
    localparam int MAXP   = (CR_POLLS > SR_POLLS) ? CR_POLLS : SR_POLLS;
    localparam int ATT_W  = $clog2(MAXP + 1);

    cdl_state_e        state;
    logic              is_probe, phase;
    logic [ATT_W-1:0]  attempts;
    logic [2:0]        idx;
    logic [WORD_W-1:0] remain, burst_left, burst;
    logic [31:0]       word_q, id_q, id_word;
    logic              done_q, vac_zero, tmr_exp, tmr_load, acc;
    logic [GAP_W-1:0]  tmr_val;
    cdl_err_e          err_q;

    cdl_id_stream u_ids (.idx_i(idx), .word_o(id_word));

    cdl_burst_calc #(.CW(WORD_W)) u_burst (
        .vac_i(bus_rdata_i), .remain_i(remain),
        .burst_o(burst), .vac_zero_o(vac_zero));

    // timer reloads outside wait states; gap chosen by the leaving state
    always_comb begin
        tmr_load = !(state == S_CR_WAIT || state == S_CMP_WAIT);
        tmr_val  = (state == S_CR_RD && bus_rdata_i[0]) ? GAP_W'(CR_GAP)
                                                        : GAP_W'(SR_GAP);
    end

    cdl_gap_timer #(.W(GAP_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
        .value_i(tmr_val), .expired_o(tmr_exp));

    // bus access driven by the current state
    always_comb begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b0;
        bus_addr_o  = REG_STAT;
        bus_wdata_o = 32'd0;
        src_ready_o = 1'b0;
        case (state)
            S_IRQ_OFF:  begin bus_we_o = 1'b1; bus_addr_o = REG_IRQ_EN; end
            S_STAT_CHK: bus_addr_o = REG_STAT;
            S_VAC_CHK:  bus_addr_o = REG_VACANT;
            S_ID_WR:    begin bus_we_o = 1'b1; bus_addr_o = REG_WFIFO; bus_wdata_o = id_word; end
            S_KICK:     begin bus_we_o = 1'b1; bus_addr_o = REG_CTRL; bus_wdata_o = 32'd1; end
            S_CR_RD:    bus_addr_o = REG_CTRL;
            S_CMP_RD:   bus_addr_o = REG_STAT;
            S_SIZE_WR:  begin bus_we_o = 1'b1; bus_addr_o = REG_SIZE; bus_wdata_o = 32'd1; end
            S_RDMODE:   begin bus_we_o = 1'b1; bus_addr_o = REG_CTRL; bus_wdata_o = 32'd2; end
            S_RF_RD:    bus_addr_o = REG_RFIFO;
            S_DL_VAC:   bus_addr_o = REG_VACANT;
            S_DL_WR:    begin bus_we_o = 1'b1; bus_addr_o = REG_WFIFO; bus_wdata_o = word_q; end
            S_FETCH:    begin bus_req_o = 1'b0; src_ready_o = 1'b1; end
            default:    bus_req_o = 1'b0;
        endcase
    end

    assign acc = bus_req_o && bus_ack_i;

    // job sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; is_probe <= 1'b0; phase <= 1'b0;
            attempts <= '0; idx <= '0; remain <= '0; burst_left <= '0;
            word_q <= '0; id_q <= '0; done_q <= 1'b0; err_q <= CDL_OK;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (probe_i) begin
                        is_probe <= 1'b1; phase <= 1'b0; state <= S_IRQ_OFF;
                    end else if (start_i) begin
                        is_probe <= 1'b0; attempts <= '0;
                        if (len_bytes_i[1:0] != 2'b00) begin
                            done_q <= 1'b1; err_q <= CDL_BADLEN;
                        end else begin
                            remain <= len_bytes_i[LEN_W-1:2];
                            state  <= (len_bytes_i[LEN_W-1:2] == '0) ? S_CMP_WAIT : S_DL_VAC;
                        end
                    end
                end
                S_IRQ_OFF: if (acc) state <= S_STAT_CHK;
                S_STAT_CHK: if (acc) begin
                    if (bus_rdata_i == 32'h1) state <= S_VAC_CHK;
                    else begin done_q <= 1'b1; err_q <= CDL_NODEV; state <= S_IDLE; end
                end
                S_VAC_CHK: if (acc) begin
                    if (bus_rdata_i >= 32'(MIN_VAC)) begin idx <= '0; state <= S_ID_WR; end
                    else begin done_q <= 1'b1; err_q <= CDL_NODEV; state <= S_IDLE; end
                end
                S_ID_WR: if (acc) begin
                    if (idx == 3'(ID_WORDS - 1)) state <= S_KICK;
                    else idx <= idx + 3'd1;
                end
                S_KICK: if (acc) begin attempts <= '0; state <= S_CR_RD; end
                S_CR_RD: if (acc) begin
                    if (!bus_rdata_i[0]) begin
                        attempts <= '0;
                        state <= (is_probe || remain == '0) ? S_CMP_WAIT : S_DL_VAC;
                    end else if (attempts == ATT_W'(CR_POLLS - 1)) begin
                        done_q <= 1'b1; err_q <= CDL_IOERR; state <= S_IDLE;
                    end else begin
                        attempts <= attempts + 1'b1; state <= S_CR_WAIT;
                    end
                end
                S_CR_WAIT:  if (tmr_exp) state <= S_CR_RD;
                S_CMP_WAIT: if (tmr_exp) state <= S_CMP_RD;
                S_CMP_RD: if (acc) begin
                    if (bus_rdata_i[0] || bus_rdata_i[2]) begin
                        attempts <= '0;
                        if (!is_probe) begin
                            done_q <= 1'b1; err_q <= CDL_OK; state <= S_IDLE;
                        end else if (!phase) begin
                            phase <= 1'b1; state <= S_SIZE_WR;
                        end else state <= S_RF_RD;
                    end else if (attempts == ATT_W'(SR_POLLS - 1)) begin
                        done_q <= 1'b1; err_q <= CDL_TIMEOUT; state <= S_IDLE;
                    end else begin
                        attempts <= attempts + 1'b1; state <= S_CMP_WAIT;
                    end
                end
                S_SIZE_WR: if (acc) state <= S_RDMODE;
                S_RDMODE:  if (acc) begin attempts <= '0; state <= S_CMP_WAIT; end
                S_RF_RD: if (acc) begin
                    id_q <= bus_rdata_i; done_q <= 1'b1; err_q <= CDL_OK; state <= S_IDLE;
                end
                S_DL_VAC: if (acc) begin
                    if (vac_zero) begin done_q <= 1'b1; err_q <= CDL_IOERR; state <= S_IDLE; end
                    else begin burst_left <= burst; state <= S_FETCH; end
                end
                S_FETCH: if (src_valid_i) begin word_q <= src_data_i; state <= S_DL_WR; end
                S_DL_WR: if (acc) begin
                    remain     <= remain - 1'b1;
                    burst_left <= burst_left - 1'b1;
                    state      <= (burst_left == WORD_W'(1)) ? S_KICK : S_FETCH;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign id_o   = id_q;
    assign done_o = done_q;
    assign err_o  = err_q;

    // R13
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
                                    && $stable(bus_we_o) && $stable(bus_wdata_o));
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R12
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !bus_req_o && !src_ready_o);
    // R8
    badlen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_IDLE && start_i && !probe_i && len_bytes_i[1:0] != 2'b00
        |=> done_o && err_o == 3'd4 && !bus_req_o);
    // R9
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_DL_WR |-> burst_left != '0 && burst_left <= remain);
    // R5
    attempt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attempts <= ATT_W'(MAXP - 1));
endmodule

// File: tb/tb_cdl_seq_top.sv
module tb_cdl_seq_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic probe_i = 1'b0, start_i = 1'b0;
    logic [23:0] len_bytes_i = '0;
    logic src_valid_i, src_ready_o;
    logic [31:0] src_data_i;
    logic bus_req_o, bus_we_o, bus_ack_i = 1'b0;
    logic [11:0] bus_addr_o;
    logic [31:0] bus_wdata_o, bus_rdata_i = '0, id_o;
    logic done_o;
    logic [2:0] err_o;

    always #10 clk = ~clk;

    cdl_seq_top dut (.*);

    int checks = 0, errors = 0, cyc = 0;
    int lat = 0, wcnt = 0;
    logic [31:0] sr_q[$], vac_q[$], cr_q[$];
    logic [31:0] rf_word = 32'h1234_ABCD;
    logic [44:0] exp_q[$];
    string exp_tag[$];
    logic [31:0] src_mem [32];
    int src_n = 0, sp = 0;
    bit dflag = 0, pend_low = 0, running = 0, hold_v = 0;
    logic [2:0] last_err;
    logic [11:0] h_addr; logic h_we; logic [31:0] h_wd;

    assign src_valid_i = (sp < src_n);
    assign src_data_i  = src_mem[sp[4:0]];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // responder model of the configuration port controller
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin bus_ack_i <= 1'b0; wcnt = 0; end
        else if (bus_ack_i) bus_ack_i <= 1'b0;
        else if (bus_req_o) begin
            if (wcnt < lat) wcnt++;
            else begin
                wcnt = 0;
                bus_ack_i <= 1'b1;
                if (!bus_we_o) begin
                    case (bus_addr_o)
                        12'h110: bus_rdata_i <= (sr_q.size() != 0) ? sr_q.pop_front() : 32'h1;
                        12'h114: bus_rdata_i <= (vac_q.size() != 0) ? vac_q.pop_front() : 32'd16;
                        12'h10C: bus_rdata_i <= (cr_q.size() != 0) ? cr_q.pop_front() : 32'h0;
                        12'h104: bus_rdata_i <= rf_word;
                        default: bus_rdata_i <= 32'hDEAD_BEEF;
                    endcase
                end
            end
        end
        if (rst_n && src_ready_o && src_valid_i) sp <= sp + 1;
    end

    // per-cycle comparison against the expected transaction list
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_low) begin
                chk(!done_o, "R12", "done width", 64'(done_o), 64'd0);
                pend_low = 0;
            end else if (done_o) begin
                chk(running, "R12", "unexpected done", 64'(done_o), 64'd0);
                dflag = 1; pend_low = 1; last_err = err_o;
            end
            if (bus_req_o) begin
                if (hold_v)
                    chk(bus_addr_o == h_addr && bus_we_o == h_we && bus_wdata_o == h_wd,
                        "R13", "request hold", {20'd0, bus_addr_o, bus_wdata_o}, {20'd0, h_addr, h_wd});
                if (bus_ack_i) hold_v = 0;
                else begin hold_v = 1; h_addr = bus_addr_o; h_we = bus_we_o; h_wd = bus_wdata_o; end
            end else hold_v = 0;
            if (bus_req_o && bus_ack_i) begin
                if (exp_q.size() == 0)
                    chk(0, "R12", "extra access", {19'd0, bus_we_o, bus_addr_o, bus_wdata_o}, 64'd0);
                else begin
                    logic [44:0] e; string t;
                    e = exp_q.pop_front(); t = exp_tag.pop_front();
                    chk(e[44] == bus_we_o && e[43:32] == bus_addr_o && (!e[44] || e[31:0] == bus_wdata_o),
                        t, "access", {19'd0, bus_we_o, bus_addr_o, bus_wdata_o}, {19'd0, e});
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic ew(input logic [11:0] a, input logic [31:0] d, input string t);
        exp_q.push_back({1'b1, a, d}); exp_tag.push_back(t);
    endtask
    task automatic er(input logic [11:0] a, input string t);
        exp_q.push_back({1'b0, a, 32'd0}); exp_tag.push_back(t);
    endtask
    task automatic idstream();
        ew(12'h100, 32'hFFFFFFFF, "R4"); ew(12'h100, 32'hAA995566, "R4");
        ew(12'h100, 32'h20000000, "R4"); ew(12'h100, 32'h20000000, "R4");
        ew(12'h100, 32'h28018001, "R4"); ew(12'h100, 32'h20000000, "R4");
        ew(12'h100, 32'h20000000, "R4"); ew(12'h10C, 32'd1, "R4");
    endtask
    task automatic clearq();
        sr_q.delete(); vac_q.delete(); cr_q.delete(); exp_q.delete(); exp_tag.delete();
    endtask
    task automatic do_probe();
        @(negedge clk); probe_i = 1; running = 1; dflag = 0;
        @(negedge clk); probe_i = 0;
    endtask
    task automatic do_start(input logic [23:0] len);
        @(negedge clk); start_i = 1; len_bytes_i = len; running = 1; dflag = 0;
        @(negedge clk); start_i = 0;
    endtask
    task automatic finish_job(input string t, input logic [2:0] e);
        while (!dflag) @(negedge clk);
        chk(last_err == e, t, "result code", 64'(last_err), 64'(e));
        chk(exp_q.size() == 0, t, "missing accesses", 64'(exp_q.size()), 64'd0);
        @(negedge clk); @(negedge clk); running = 0;
    endtask

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!bus_req_o && !src_ready_o && !done_o && err_o == 0 && id_o == 0, "R1", "reset outputs",
            {bus_req_o, src_ready_o, done_o, err_o, id_o}, 64'd0);
        rst_n = 1;
        @(negedge clk);

        // R2 status not 1
        clearq(); sr_q.push_back(32'h0);
        ew(12'h01C, 32'd0, "R2"); er(12'h110, "R2");
        do_probe(); finish_job("R2", 3'd1);

        // R3 vacancy too small
        clearq(); sr_q.push_back(32'h1); vac_q.push_back(32'd7);
        ew(12'h01C, 32'd0, "R3"); er(12'h110, "R3"); er(12'h114, "R3");
        do_probe(); finish_job("R3", 3'd1);

        // R4 R5 R6 R7 full probe
        clearq(); lat = 2;
        sr_q = '{32'h1, 32'h0, 32'h0, 32'h4, 32'h1}; vac_q.push_back(32'd8);
        cr_q = '{32'h1, 32'h1, 32'h0};
        ew(12'h01C, 32'd0, "R2"); er(12'h110, "R2"); er(12'h114, "R3"); idstream();
        er(12'h10C, "R5"); er(12'h10C, "R5"); er(12'h10C, "R5");
        er(12'h110, "R6"); er(12'h110, "R6"); er(12'h110, "R6");
        ew(12'h108, 32'd1, "R7"); ew(12'h10C, 32'd2, "R7"); er(12'h110, "R7"); er(12'h104, "R7");
        do_probe(); finish_job("R7", 3'd0);
        chk(id_o == 32'h1234_ABCD, "R7", "captured ID", 64'(id_o), 64'h1234_ABCD);
        lat = 0;

        // R5 control bit never clears
        clearq(); sr_q.push_back(32'h1);
        for (int i = 0; i < 20; i++) cr_q.push_back(32'h1);
        ew(12'h01C, 32'd0, "R2"); er(12'h110, "R2"); er(12'h114, "R3"); idstream();
        for (int i = 0; i < 20; i++) er(12'h10C, "R5");
        do_probe(); finish_job("R5", 3'd2);

        // R6 completion never seen
        clearq(); sr_q.push_back(32'h1);
        for (int i = 0; i < 10; i++) sr_q.push_back(32'h2);
        ew(12'h01C, 32'd0, "R2"); er(12'h110, "R2"); er(12'h114, "R3"); idstream();
        er(12'h10C, "R5");
        for (int i = 0; i < 10; i++) er(12'h110, "R6");
        t0 = cyc;
        do_probe(); finish_job("R6", 3'd3);
        chk(cyc - t0 >= 2500, "R6", "poll spacing", 64'(cyc - t0), 64'd2500);

        // R8 bad length
        clearq(); sp = 0; src_n = 4;
        for (int i = 0; i < 4; i++) src_mem[i] = 32'h5A00_0000 + i;
        do_start(24'd10); finish_job("R8", 3'd4);
        chk(sp == 0, "R8", "source untouched", 64'(sp), 64'd0);

        // R9 R11 R12 download 10 words in two bursts, with ignored commands
        clearq(); sp = 0; src_n = 10; lat = 1;
        for (int i = 0; i < 10; i++) src_mem[i] = 32'hC0DE_0000 ^ (i * 32'h0101_0101);
        vac_q = '{32'd4, 32'd8}; sr_q = '{32'h0, 32'h5};
        er(12'h114, "R9");
        for (int i = 0; i < 4; i++) ew(12'h100, 32'hC0DE_0000 ^ (i * 32'h0101_0101), "R9");
        ew(12'h10C, 32'd1, "R9"); er(12'h10C, "R9"); er(12'h114, "R9");
        for (int i = 4; i < 10; i++) ew(12'h100, 32'hC0DE_0000 ^ (i * 32'h0101_0101), "R9");
        ew(12'h10C, 32'd1, "R9"); er(12'h10C, "R9");
        er(12'h110, "R11"); er(12'h110, "R11");
        do_start(24'd40);
        repeat (5) @(negedge clk);
        probe_i = 1; @(negedge clk); probe_i = 0;       // R12 ignored
        start_i = 1; len_bytes_i = 24'd3; @(negedge clk); start_i = 0;
        finish_job("R11", 3'd0);
        chk(sp == 10, "R9", "words consumed", 64'(sp), 64'd10);
        lat = 0;

        // R10 zero vacancy mid-download
        clearq(); sp = 0; src_n = 5;
        vac_q = '{32'd3, 32'd0};
        er(12'h114, "R10");
        for (int i = 0; i < 3; i++) ew(12'h100, src_mem[i], "R10");
        ew(12'h10C, 32'd1, "R10"); er(12'h10C, "R10"); er(12'h114, "R10");
        do_start(24'd20); finish_job("R10", 3'd2);
        chk(sp == 3, "R10", "words consumed", 64'(sp), 64'd3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule